// File: doc/BRIEF.md
# Service-Keyed Watchdog Timer

This block is a watchdog timer driven through a byte-wide register port. One register takes service bytes. Writing the kick code starts the watchdog or restarts its countdown. A fixed three-byte stop sequence halts the watchdog and opens its configuration registers to writes.

To keep a stray stop from landing right after a service write, a guard window refuses the stop sequence until three watchdog ticks have passed since the most recent kick. Watchdog ticks come from a reference-clock enable, divided by a power-of-two prescaler whose shift is software-programmable.

While the watchdog runs, a level early-warning interrupt rises when the remaining tick count drops to a programmed threshold. When the count runs out, the block pulses a one-cycle reset request, reloads the count and keeps running.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the watchdog is stopped and unlocked, and its guard is satisfied. The prescaler shift reads 0x0A, the timeout reads 32 and the warning threshold reads 4. Reads at address 0 return status: bit 0 is running, bit 1 is unlocked, bit 2 is guard satisfied, and the other bits are zero. Address 1 reads the prescaler shift (low 4 bits), address 2 the timeout and address 3 the warning threshold.
- R2: Writing 0x5C to address 0 loads the countdown with the timeout and restarts the prescaler. It also sets running and locks the configuration, and it changes no configuration value.
- R3: The writes 0x87, 0x61 and 0x63 to address 0, in that order and with the guard satisfied, stop the watchdog and unlock the configuration.
- R4: The guard counts watchdog ticks from the last 0x5C write and saturates at 3. A stop sequence that completes while fewer than 3 ticks have passed has no effect.
- R5: At address 0, a byte that does not continue the stop sequence sends the matcher back to its first step, and 0x87 always counts as a first step. Writes to other addresses do not disturb the matcher.
- R6: Writes to addresses 1 to 3 take effect only while unlocked. While locked they are ignored and the readback is unchanged.
- R7: A watchdog tick occurs once every 2^shift reference-tick pulses, counted from the last 0x5C write.
- R8: warnIrq is high exactly while running with a remaining count no greater than the warning threshold.
- R9: After timeout ticks with no 0x5C write, resetReq is high for exactly one cycle, namely the cycle after the edge of the final tick. The countdown then reloads and the watchdog keeps running.
- R10: While stopped, the countdown holds and resetReq stays low.
- R11: rdData follows rdAddr combinationally, and a write is visible in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference-clock enable pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data |
| running | output | 1 | Watchdog is counting |
| warnIrq | output | 1 | Early-warning interrupt |
| resetReq | output | 1 | One-cycle reset request on expiry |

## Verification
Writes to the configuration and status registers, and the running and warning outputs, are due in the cycle right after the clock edge that takes the write or the tick. resetReq is due one cycle after the edge of the final tick and is gone one cycle later. The bench drives every input at the falling edge, advances its reference model for that same edge, and compares all outputs 2 ns after the rising edge. Each compare therefore sees exactly the state after one edge. Directed runs place the guard boundary (two and three ticks), the prescaler boundary (seven and eight pulses at shift 2) and the broken stop sequences on known cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KICK_CODE = 8'h5C;
  localparam logic [7:0] STOP_B0   = 8'h87;
  localparam logic [7:0] STOP_B1   = 8'h61;
  localparam logic [7:0] STOP_B2   = 8'h63;

  localparam logic [1:0] A_SVC   = 2'd0;
  localparam logic [1:0] A_SHIFT = 2'd1;
  localparam logic [1:0] A_TOUT  = 2'd2;
  localparam logic [1:0] A_WARN  = 2'd3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_GOT0, SEQ_GOT1} seqStep_t;

  typedef struct packed {
    logic kick;   // reload countdown, restart prescaler
    logic cfgWe;  // configuration write accepted
    logic run;    // watchdog counting
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int GUARD_TICKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       wdTick,
  output wdtStrobe_t strobe,
  output logic       unlocked,
  output logic       guardOk
);
  localparam int GW = $clog2(GUARD_TICKS + 1);
  localparam logic [GW-1:0] GUARD_MAX = GW'(GUARD_TICKS);

  seqStep_t      seqStep;
  logic [GW-1:0] guardCnt;
  logic          runQ;
  logic          svcWr, kick, seqDone, stopOk;

  always_comb begin
    svcWr   = wrEn && (wrAddr == A_SVC);
    kick    = svcWr && (wrData == KICK_CODE);
    seqDone = svcWr && (seqStep == SEQ_GOT1) && (wrData == STOP_B2);
    guardOk = (guardCnt == GUARD_MAX);
    stopOk  = seqDone && guardOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqStep <= SEQ_IDLE;
    end else if (svcWr) begin
      if (wrData == STOP_B0)
        seqStep <= SEQ_GOT0;
      else if (seqStep == SEQ_GOT0 && wrData == STOP_B1)
        seqStep <= SEQ_GOT1;
      else
        seqStep <= SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      unlocked <= 1'b1;
      guardCnt <= GUARD_MAX;
    end else begin
      if (kick) begin
        runQ     <= 1'b1;
        unlocked <= 1'b0;
      end else if (stopOk) begin
        runQ     <= 1'b0;
        unlocked <= 1'b1;
      end
      if (kick)
        guardCnt <= '0;
      else if (wdTick && !guardOk)
        guardCnt <= guardCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.kick  = kick;
    strobe.cfgWe = wrEn && (wrAddr != A_SVC) && unlocked;
    strobe.run   = runQ;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRESC_W     = 4,
  parameter int CNT_W       = 8,
  parameter int DEF_SHIFT   = 10,
  parameter int DEF_TIMEOUT = 32,
  parameter int DEF_WARN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  wdtStrobe_t strobe,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  input  logic [2:0] statusBits,
  output logic       wdTick,
  output logic [7:0] rdData,
  output logic       warnIrq,
  output logic       resetReq
);
  localparam int PCNT_W = (1 << PRESC_W) - 1;

  logic [PRESC_W-1:0] shiftReg;
  logic [CNT_W-1:0]   toutReg, warnReg, count;
  logic [PCNT_W-1:0]  preCnt, preMask;
  logic               preWrap;

  always_comb begin
    preMask = ~({PCNT_W{1'b1}} << shiftReg);
    preWrap = (preCnt >= preMask);
    wdTick  = refTick && preWrap && !strobe.kick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= PRESC_W'(DEF_SHIFT);
      toutReg  <= CNT_W'(DEF_TIMEOUT);
      warnReg  <= CNT_W'(DEF_WARN);
    end else if (strobe.cfgWe) begin
      case (wrAddr)
        A_SHIFT: shiftReg <= wrData[PRESC_W-1:0];
        A_TOUT:  toutReg  <= wrData[CNT_W-1:0];
        A_WARN:  warnReg  <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      preCnt <= '0;
    else if (strobe.kick)
      preCnt <= '0;
    else if (refTick)
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= CNT_W'(DEF_TIMEOUT);
      resetReq <= 1'b0;
    end else begin
      resetReq <= 1'b0;
      if (strobe.kick) begin
        count <= toutReg;
      end else if (strobe.run && wdTick) begin
        if (count <= CNT_W'(1)) begin
          count    <= toutReg;
          resetReq <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  assign warnIrq = strobe.run && (count <= warnReg);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_SVC:   rdData[2:0] = statusBits;
      A_SHIFT: rdData[PRESC_W-1:0] = shiftReg;
      A_TOUT:  rdData[CNT_W-1:0] = toutReg;
      default: rdData[CNT_W-1:0] = warnReg;
    endcase
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdt_pkg::*;
#(
  parameter int PRESC_W     = 4,
  parameter int CNT_W       = 8,
  parameter int DEF_SHIFT   = 10,
  parameter int DEF_TIMEOUT = 32,
  parameter int DEF_WARN    = 4,
  parameter int GUARD_TICKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  output logic       running,
  output logic       warnIrq,
  output logic       resetReq
);
  wdtStrobe_t strobe;
  logic       unlocked, guardOk, wdTick;
  logic [2:0] statusBits;

  wdt_ctrl #(.GUARD_TICKS(GUARD_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wdTick(wdTick), .strobe(strobe), .unlocked(unlocked), .guardOk(guardOk)
  );

  assign statusBits = {guardOk, unlocked, strobe.run};
  assign running    = strobe.run;

  wdt_datapath #(
    .PRESC_W(PRESC_W), .CNT_W(CNT_W), .DEF_SHIFT(DEF_SHIFT),
    .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_WARN(DEF_WARN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .statusBits(statusBits),
    .wdTick(wdTick), .rdData(rdData), .warnIrq(warnIrq), .resetReq(resetReq)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [7:0] wrData,
  input logic       running,
  input logic       unlocked,
  input logic       guardOk,
  input logic       warnIrq,
  input logic       resetReq
);
  logic kickWr;
  assign kickWr = wrEn && (wrAddr == 2'd0) && (wrData == 8'h5C);

  p_kick_arms_r2: assert property (@(posedge clk) disable iff (!rstN)
    kickWr |=> (running && !unlocked));

  p_unlock_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |-> !running);

  p_guard_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (running && !guardOk) |=> running);

  p_warn_running_r8: assert property (@(posedge clk) disable iff (!rstN)
    warnIrq |-> running);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !resetReq);
endmodule

bind svc_watchdog wdt_checker u_wdt_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .running(running), .unlocked(unlocked), .guardOk(guardOk),
  .warnIrq(warnIrq), .resetReq(resetReq)
);

// File: tb/test_svc_watchdog.sv
module test_svc_watchdog;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       running, warnIrq, resetReq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  svc_watchdog i_svc_watchdog (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .running(running),
    .warnIrq(warnIrq), .resetReq(resetReq)
  );

  // reference model state
  int mRun, mUnl, mShift, mTo, mWarn, mCnt, mGuard, mPre, mStep, mRst;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRead(input int a);
    case (a)
      0: return ((mGuard >= 3) ? 4 : 0) | (mUnl ? 2 : 0) | (mRun ? 1 : 0);
      1: return mShift;
      2: return mTo;
      default: return mWarn;
    endcase
  endfunction

  task automatic modelInit();
    mRun = 0; mUnl = 1; mShift = 10; mTo = 32; mWarn = 4;
    mCnt = 32; mGuard = 3; mPre = 0; mStep = 0; mRst = 0;
  endtask

  task automatic modelStep(input bit we, input int a, input int d, input bit rt);
    bit svc, kick, done, tick;
    int mask;
    svc  = we && (a == 0);
    kick = svc && (d == 8'h5C);
    done = svc && (mStep == 2) && (d == 8'h63);
    mask = (1 << mShift) - 1;
    tick = rt && !kick && (mPre >= mask);
    mRst = 0;
    if (kick) mCnt = mTo;
    else if (mRun && tick) begin
      if (mCnt <= 1) begin mCnt = mTo; mRst = 1; end
      else mCnt = mCnt - 1;
    end
    if (kick) mPre = 0;
    else if (rt) mPre = tick ? 0 : mPre + 1;
    if (we && a != 0 && mUnl) begin
      if (a == 1) mShift = d & 15;
      else if (a == 2) mTo = d;
      else mWarn = d;
    end
    if (kick) begin mRun = 1; mUnl = 0; end
    else if (done && mGuard >= 3) begin mRun = 0; mUnl = 1; end
    if (kick) mGuard = 0;
    else if (tick && mGuard < 3) mGuard = mGuard + 1;
    if (svc) begin
      if (d == 8'h87) mStep = 1;
      else if (mStep == 1 && d == 8'h61) mStep = 2;
      else mStep = 0;
    end
  endtask

  task automatic cycle(input bit we, input int a, input int d, input bit rt, input int ra);
    @(negedge clk);
    wrEn = we; wrAddr = 2'(a); wrData = 8'(d); refTick = rt; rdAddr = 2'(ra);
    modelStep(we, a, d, rt);
    @(posedge clk);
    #2;
    chk("R2/R3/R4 running", int'(running), mRun);
    chk("R8 warnIrq", int'(warnIrq), (mRun && mCnt <= mWarn) ? 1 : 0);
    chk("R9/R10 resetReq", int'(resetReq), mRst);
    chk("R11 rdData", int'(rdData), expRead(ra));
    @(negedge clk);
    wrEn = 0; refTick = 0;
  endtask

  task automatic wr(input int a, input int d); cycle(1, a, d, 0, 0); endtask
  task automatic rt1(); cycle(0, 0, 0, 1, 0); endtask
  task automatic rdReg(input int a, output int v);
    @(negedge clk); rdAddr = 2'(a); #1 v = int'(rdData);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish();
  end

  initial begin
    int v;
    void'($urandom(32'h5EED_0042));
    modelInit();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    rdReg(0, v); chk("R1 status", v, 6);
    rdReg(1, v); chk("R1 shift", v, 10);
    rdReg(2, v); chk("R1 timeout", v, 32);
    rdReg(3, v); chk("R1 warn", v, 4);
    chk("R1 running", int'(running), 0);
    // configure while unlocked
    wr(1, 0); wr(2, 6); wr(3, 2);
    rdReg(2, v); chk("R6 unlocked write", v, 6);
    wr(0, 8'h5C);
    rdReg(0, v); chk("R2 status after kick", v, 1);
    rdReg(2, v); chk("R2 timeout unchanged", v, 6);
    wr(2, 9);
    rdReg(2, v); chk("R6 locked write ignored", v, 6);
    // stop inside guard window: refused
    wr(0, 8'h87); wr(0, 8'h61); wr(0, 8'h63);
    chk("R4 refused at 0 ticks", int'(running), 1);
    rt1(); rt1();
    wr(0, 8'h87); wr(0, 8'h61); wr(0, 8'h63);
    chk("R4 refused at 2 ticks", int'(running), 1);
    rt1();
    rdReg(0, v); chk("R4 guard satisfied", v, 5);
    // broken sequence
    wr(0, 8'h87); wr(0, 8'h61); wr(0, 8'h12); wr(0, 8'h63);
    chk("R5 broken sequence", int'(running), 1);
    wr(0, 8'h61); wr(0, 8'h63);
    chk("R5 out of order", int'(running), 1);
    rt1();
    chk("R8 warn at count 2", int'(warnIrq), 1);
    wr(0, 8'h87); wr(0, 8'h87); wr(0, 8'h61); wr(0, 8'h63);
    chk("R3 stopped", int'(running), 0);
    rdReg(0, v); chk("R3 status", v, 6);
    chk("R8 warn off when stopped", int'(warnIrq), 0);
    for (int i = 0; i < 10; i++) begin
      rt1();
      chk("R10 no reset while stopped", int'(resetReq), 0);
    end
    // prescaler shift 2, timeout 2
    wr(1, 2); wr(2, 2); wr(0, 8'h5C);
    for (int i = 0; i < 7; i++) rt1();
    chk("R7 no expiry after 7 pulses", int'(resetReq), 0);
    rt1();
    chk("R7/R9 expiry after 8 pulses", int'(resetReq), 1);
    cycle(0, 0, 0, 0, 0);
    chk("R9 single cycle pulse", int'(resetReq), 0);
    chk("R9 keeps running", int'(running), 1);
    for (int i = 0; i < 4; i++) rt1();
    wr(0, 8'h87); wr(3, 8'h55); wr(0, 8'h61); wr(0, 8'h63);
    chk("R5 other address does not break", int'(running), 0);
    rdReg(3, v); chk("R6 locked warn write ignored", v, 2);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r, a, d;
      bit we, rt;
      r  = int'($urandom_range(0, 99));
      rt = ($urandom_range(0, 2) == 0);
      we = (r < 40);
      a = 0; d = 0;
      if (we) begin
        if (r < 8) d = 8'h5C;
        else if (r < 14) d = 8'h87;
        else if (r < 20) d = 8'h61;
        else if (r < 26) d = 8'h63;
        else if (r < 30) d = int'($urandom_range(0, 255));
        else begin
          a = int'($urandom_range(1, 3));
          d = (a == 1) ? int'($urandom_range(0, 2)) : int'($urandom_range(1, 12));
        end
      end
      cycle(we, a, d, rt, int'($urandom_range(0, 3)));
    end
    finish();
  end
endmodule